// File: doc/BRIEF.md
# Strided Local-Memory DMA Engine

This engine copies 32-bit words between a large external memory and a small on-chip memory. The on-chip memory has two equal banks, one for instructions and one for data. Software loads a local address and an external address through a small register port. It then writes a shape word to one of two start registers, and the register it picks sets the direction. The shape word holds the row length, the row count and a skip stride. Together these describe a transfer that can span several rows, with a gap between the rows.

Each word is read from the source memory first and then written to the destination memory. Both memories use a request/grant handshake. The engine fixes the row length and the external address before it starts. While a transfer runs it steps the local and external addresses itself. Software reads the final addresses back once `done` has pulsed.

Top module: `stride_dma`

## Requirements
- R1: A start write whose length field (shape bits [11:0]) is zero starts nothing. `busy` and `done` stay low, neither memory is requested, and the address and shape registers keep their values.
- R2: The bytes in a row equal the length field plus one, rounded up to the next multiple of 4. Each row moves that many bytes divided by 4 words.
- R3: When a transfer starts, an external address with bit 0 or bit 1 set has its three low bits cleared. An external address that is already a multiple of 4 is kept as it is. The new value can be read back at register select 1.
- R4: Local address bit 12 selects the bank (1 instruction, 0 data), and bits [11:0] give the byte offset in that bank. Word k of a row goes to word index (offset + 4k) mod 4096 divided by 4, in the same bank.
- R5: The row field (shape bits [19:12]) holds the row count minus one.
- R6: After each row, both the local address and the external address grow by the rounded row byte count. The local address is 13 bits and wraps.
- R7: After each row, the skip field (shape bits [31:20], in bytes) is also added. It goes to the external address when the transfer was started at select 3 (local to external). It goes to the local address when started at select 2 (external to local).
- R8: `overrun` is set when a row's local offset plus its rounded byte count is greater than 4096. It holds until the next accepted start, which clears it.
- R9: `busy` is high from the cycle after an accepted start until the last word of the last row has been written. `done` is high for exactly the one cycle in which `busy` has just fallen.
- R10: While `busy` is high, every register write (address or start) is ignored.
- R11: Every word is read from the source and then written to the destination. A request holds its address until it is granted. Words within a row go in ascending address order, and rows follow one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 local address, 1 external address, 2 start external-to-local, 3 start local-to-external |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_sel (2 and 3 both return the last accepted shape) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| overrun | output | 1 | A row ran past the end of its local bank |
| loc_req | output | 1 | Local memory request |
| loc_we | output | 1 | Local request is a write |
| loc_bank | output | 1 | Local bank (1 instruction, 0 data) |
| loc_waddr | output | 10 | Local word index in the bank |
| loc_wdata | output | 32 | Local write data |
| loc_gnt | input | 1 | Local grant |
| loc_rdata | input | 32 | Local read data, valid when granted |
| ext_req | output | 1 | External memory request |
| ext_we | output | 1 | External request is a write |
| ext_addr | output | 32 | External byte address |
| ext_wdata | output | 32 | External write data |
| ext_gnt | input | 1 | External grant |
| ext_rdata | input | 32 | External read data, valid when granted |

## Verification
The bench predicts every destination write from the register values it programmed. A faulty word counter or a wrong round-up shows up at the first row boundary, as a missing, extra or misaddressed write. A wrong alignment or a wrong skip target shows on the first word of the second row, or in the address read back right after start or after `done`. A broken bank-limit check shows as a wrong `overrun` when `done` pulses. An engine that fails to ignore writes while busy or zero-length starts produces writes the bench did not expect, or address values it did not predict.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int unsigned LEN_W  = 12;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned SKIP_W = 12;

  typedef struct packed {
    logic [SKIP_W-1:0] skip;
    logic [CNT_W-1:0]  rows_m1;
    logic [LEN_W-1:0]  len_m1;
  } shape_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2
  } dma_st_e;

  typedef enum logic {
    DIR_TO_LOC = 1'b0,
    DIR_TO_EXT = 1'b1
  } dma_dir_e;
endpackage

// File: rtl/sdma_decode.sv
module sdma_decode
  import sdma_pkg::*;
#(
  parameter int unsigned EXT_AW = 32
) (
  input  shape_t              shape,
  input  logic [EXT_AW-1:0]   ext_raw,
  output logic [LEN_W:0]      row_bytes,
  output logic [EXT_AW-1:0]   ext_fixed
);
  localparam int unsigned SUM_W = LEN_W + 2;

  logic [SUM_W-1:0] bytes_plus;

  // length field is minus-one coded; round up to whole words
  always_comb begin
    bytes_plus = SUM_W'(shape.len_m1) + SUM_W'(4);
    bytes_plus[1:0] = 2'b00;
    row_bytes = bytes_plus[LEN_W:0];
  end

  // unaligned external address drops to an 8-byte boundary
  always_comb begin
    ext_fixed = ext_raw;
    if (ext_raw[1:0] != 2'b00) begin
      ext_fixed[2:0] = 3'b000;
    end
  end
endmodule

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int unsigned EXT_AW = 32,
  parameter int unsigned LOC_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              row_adv,
  input  logic [LEN_W:0]    row_bytes,
  input  logic [EXT_AW-1:0] ext_fixed,
  output logic              start,
  output dma_dir_e          dir_q,
  output shape_t            shape_q,
  output logic [LOC_AW:0]   loc_q,
  output logic [EXT_AW-1:0] ext_q
);
  localparam int unsigned LA_W = LOC_AW + 1;

  logic [LOC_AW:0]   loc_d;
  logic [EXT_AW-1:0] ext_d;
  shape_t            shape_d;
  dma_dir_e          dir_d;
  logic              reg_en;
  logic              sw_wr;
  logic [LOC_AW:0]   loc_skip;
  logic [EXT_AW-1:0] ext_skip;

  assign sw_wr = reg_we && !busy;

  always_comb begin
    loc_skip = '0;
    ext_skip = '0;
    if (dir_q == DIR_TO_LOC) begin
      loc_skip = LA_W'(shape_q.skip);
    end else begin
      ext_skip = EXT_AW'(shape_q.skip);
    end
  end

  always_comb begin
    loc_d   = loc_q;
    ext_d   = ext_q;
    shape_d = shape_q;
    dir_d   = dir_q;
    start   = 1'b0;
    if (sw_wr) begin
      case (reg_sel)
        2'd0: loc_d = reg_wdata[LOC_AW:0];
        2'd1: ext_d = reg_wdata[EXT_AW-1:0];
        default: begin
          if (reg_wdata[LEN_W-1:0] != '0) begin
            start   = 1'b1;
            shape_d = shape_t'(reg_wdata);
            dir_d   = dma_dir_e'(reg_sel[0]);
            ext_d   = ext_fixed;
          end
        end
      endcase
    end else if (row_adv) begin
      loc_d = loc_q + LA_W'(row_bytes) + loc_skip;
      ext_d = ext_q + EXT_AW'(row_bytes) + ext_skip;
    end
  end

  assign reg_en = sw_wr || row_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q   <= '0;
      ext_q   <= '0;
      shape_q <= '0;
      dir_q   <= DIR_TO_LOC;
    end else if (reg_en) begin
      loc_q   <= loc_d;
      ext_q   <= ext_d;
      shape_q <= shape_d;
      dir_q   <= dir_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      2'd0:    reg_rdata[LOC_AW:0]   = loc_q;
      2'd1:    reg_rdata[EXT_AW-1:0] = ext_q;
      default: reg_rdata             = 32'(shape_q);
    endcase
  end

  a_r3_ext_aligned_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ext_q[1:0] == 2'b00));

  a_r10_shape_locked_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we) |=> ($stable(shape_q) && $stable(dir_q)));

  a_r1_zero_len_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel[1] && (reg_wdata[LEN_W-1:0] == '0)) |=> $stable(shape_q));
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
#(
  parameter int unsigned EXT_AW = 32,
  parameter int unsigned LOC_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  dma_dir_e          dir,
  input  logic [LEN_W:0]    row_bytes,
  input  logic [CNT_W-1:0]  rows_m1,
  input  logic [LOC_AW:0]   loc_q,
  input  logic [EXT_AW-1:0] ext_q,
  output logic              busy,
  output logic              done,
  output logic              overrun,
  output logic              row_adv,
  output logic              loc_req,
  output logic              loc_we,
  output logic              loc_bank,
  output logic [LOC_AW-3:0] loc_waddr,
  output logic [31:0]       loc_wdata,
  input  logic              loc_gnt,
  input  logic [31:0]       loc_rdata,
  output logic              ext_req,
  output logic              ext_we,
  output logic [EXT_AW-1:0] ext_addr,
  output logic [31:0]       ext_wdata,
  input  logic              ext_gnt,
  input  logic [31:0]       ext_rdata
);
  localparam int unsigned OFF_W = LEN_W + 1;
  localparam int unsigned LS_W  = LOC_AW + 1;
  localparam int unsigned OV_W  = LOC_AW + 2;
  localparam logic [OV_W-1:0] BANK_BYTES = OV_W'(1) << LOC_AW;

  dma_st_e           st_q, st_d;
  logic [OFF_W-1:0]  off_q, off_d, off_nxt;
  logic [CNT_W-1:0]  row_q, row_d;
  logic [31:0]       data_q, data_d;
  logic              done_d, ovr_d;
  logic              st_en, data_en;
  logic              src_gnt, dst_gnt;
  logic [31:0]       src_rdata;
  logic              last_word, last_row;
  logic [LS_W-1:0]   loc_sum;
  logic [OV_W-1:0]   row_end;

  assign off_nxt   = off_q + OFF_W'(4);
  assign last_word = (off_nxt == row_bytes);
  assign last_row  = (row_q == rows_m1);

  assign src_gnt   = (dir == DIR_TO_LOC) ? ext_gnt   : loc_gnt;
  assign dst_gnt   = (dir == DIR_TO_LOC) ? loc_gnt   : ext_gnt;
  assign src_rdata = (dir == DIR_TO_LOC) ? ext_rdata : loc_rdata;

  // local word address wraps inside its bank
  assign loc_sum   = LS_W'(loc_q[LOC_AW-1:0]) + LS_W'(off_q);
  assign loc_bank  = loc_q[LOC_AW];
  assign loc_waddr = loc_sum[LOC_AW-1:2];
  assign ext_addr  = ext_q + EXT_AW'(off_q);
  assign loc_wdata = data_q;
  assign ext_wdata = data_q;

  assign row_end = OV_W'(loc_q[LOC_AW-1:0]) + OV_W'(row_bytes);

  always_comb begin
    loc_req = 1'b0;
    ext_req = 1'b0;
    loc_we  = 1'b0;
    ext_we  = 1'b0;
    case (st_q)
      ST_FETCH: begin
        if (dir == DIR_TO_LOC) ext_req = 1'b1;
        else                   loc_req = 1'b1;
      end
      ST_STORE: begin
        if (dir == DIR_TO_LOC) begin
          loc_req = 1'b1;
          loc_we  = 1'b1;
        end else begin
          ext_req = 1'b1;
          ext_we  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    off_d   = off_q;
    row_d   = row_q;
    data_d  = data_q;
    done_d  = 1'b0;
    ovr_d   = overrun;
    row_adv = 1'b0;
    data_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_FETCH;
          off_d = '0;
          row_d = '0;
          ovr_d = 1'b0;
        end
      end
      ST_FETCH: begin
        if ((off_q == '0) && (row_end > BANK_BYTES)) begin
          ovr_d = 1'b1;
        end
        if (src_gnt) begin
          data_d  = src_rdata;
          data_en = 1'b1;
          st_d    = ST_STORE;
        end
      end
      ST_STORE: begin
        if (dst_gnt) begin
          st_d = ST_FETCH;
          if (last_word) begin
            row_adv = 1'b1;
            off_d   = '0;
            if (last_row) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end else begin
              row_d = row_q + CNT_W'(1);
            end
          end else begin
            off_d = off_nxt;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign st_en = (st_q != ST_IDLE) || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      off_q   <= '0;
      row_q   <= '0;
      overrun <= 1'b0;
    end else if (st_en) begin
      st_q    <= st_d;
      off_q   <= off_d;
      row_q   <= row_d;
      overrun <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else begin
      done <= done_d;
    end
  end

  assign busy = (st_q != ST_IDLE);

  a_r1_idle_no_requests: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!loc_req && !ext_req));

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_loc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_req && !loc_gnt) |=> (loc_req && $stable(loc_waddr) && $stable(loc_we)));

  a_r11_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_gnt) |=> (ext_req && $stable(ext_addr) && $stable(ext_we)));

  a_r11_one_side_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_req && ext_req));

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !start) |=> overrun);
endmodule

// File: rtl/stride_dma.sv
module stride_dma
  import sdma_pkg::*;
#(
  parameter int unsigned EXT_AW = 32,
  parameter int unsigned LOC_AW = 12,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              busy,
  output logic              done,
  output logic              overrun,
  output logic              loc_req,
  output logic              loc_we,
  output logic              loc_bank,
  output logic [LOC_AW-3:0] loc_waddr,
  output logic [31:0]       loc_wdata,
  input  logic              loc_gnt,
  input  logic [31:0]       loc_rdata,
  output logic              ext_req,
  output logic              ext_we,
  output logic [EXT_AW-1:0] ext_addr,
  output logic [31:0]       ext_wdata,
  input  logic              ext_gnt,
  input  logic [31:0]       ext_rdata
);
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_n_i = rst_pipe[SYNC_N-1];

  logic              start;
  logic              row_adv;
  dma_dir_e          dir_q;
  shape_t            shape_q;
  logic [LOC_AW:0]   loc_q;
  logic [EXT_AW-1:0] ext_q;
  logic [LEN_W:0]    row_bytes;
  logic [EXT_AW-1:0] ext_fixed;

  sdma_decode #(.EXT_AW(EXT_AW)) i_decode (
    .shape     (shape_q),
    .ext_raw   (ext_q),
    .row_bytes (row_bytes),
    .ext_fixed (ext_fixed)
  );

  sdma_regs #(.EXT_AW(EXT_AW), .LOC_AW(LOC_AW)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .row_adv   (row_adv),
    .row_bytes (row_bytes),
    .ext_fixed (ext_fixed),
    .start     (start),
    .dir_q     (dir_q),
    .shape_q   (shape_q),
    .loc_q     (loc_q),
    .ext_q     (ext_q)
  );

  sdma_seq #(.EXT_AW(EXT_AW), .LOC_AW(LOC_AW)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start     (start),
    .dir       (dir_q),
    .row_bytes (row_bytes),
    .rows_m1   (shape_q.rows_m1),
    .loc_q     (loc_q),
    .ext_q     (ext_q),
    .busy      (busy),
    .done      (done),
    .overrun   (overrun),
    .row_adv   (row_adv),
    .loc_req   (loc_req),
    .loc_we    (loc_we),
    .loc_bank  (loc_bank),
    .loc_waddr (loc_waddr),
    .loc_wdata (loc_wdata),
    .loc_gnt   (loc_gnt),
    .loc_rdata (loc_rdata),
    .ext_req   (ext_req),
    .ext_we    (ext_we),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata),
    .ext_gnt   (ext_gnt),
    .ext_rdata (ext_rdata)
  );
endmodule

// File: tb/test_stride_dma.sv
module test_stride_dma;
  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        busy, done, overrun;
  logic        loc_req, loc_we, loc_bank, loc_gnt;
  logic [9:0]  loc_waddr;
  logic [31:0] loc_wdata, loc_rdata;
  logic        ext_req, ext_we, ext_gnt;
  logic [31:0] ext_addr, ext_wdata, ext_rdata;

  int errors = 0;
  int checks = 0;

  typedef struct packed {
    logic        to_loc;
    logic [31:0] addr;
    logic [31:0] data;
  } exp_t;
  exp_t exp_q[$];

  logic [31:0] ext_mem [0:1023];
  logic [31:0] loc_mem [0:2047];
  logic [7:0]  rnd;

  stride_dma i_stride_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .overrun(overrun), .loc_req(loc_req), .loc_we(loc_we), .loc_bank(loc_bank),
    .loc_waddr(loc_waddr), .loc_wdata(loc_wdata), .loc_gnt(loc_gnt),
    .loc_rdata(loc_rdata), .ext_req(ext_req), .ext_we(ext_we),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_gnt(ext_gnt),
    .ext_rdata(ext_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // memory models with pseudo-random grants
  assign loc_gnt   = loc_req & rnd[0];
  assign ext_gnt   = ext_req & rnd[3];
  assign loc_rdata = loc_mem[{loc_bank, loc_waddr}];
  assign ext_rdata = ext_mem[ext_addr[11:2]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rnd <= 8'h5B;
      for (int i = 0; i < 1024; i++) ext_mem[i] <= 32'hE000_0000 + i * 32'h0001_0003;
      for (int i = 0; i < 2048; i++) loc_mem[i] <= 32'h1000_0000 + i * 32'h0000_0107;
    end else begin
      rnd <= {rnd[6:0], rnd[7] ^ rnd[5] ^ rnd[4] ^ rnd[3]};
      if (loc_req && loc_we && loc_gnt) loc_mem[{loc_bank, loc_waddr}] <= loc_wdata;
      if (ext_req && ext_we && ext_gnt) ext_mem[ext_addr[11:2]] <= ext_wdata;
    end
  end

  // monitor: compare each accepted write with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t got;
      logic hit;
      hit = 1'b0;
      got = '0;
      if (loc_req && loc_we && loc_gnt) begin
        hit = 1'b1;
        got = {1'b1, {19'd0, loc_bank, loc_waddr, 2'b00}, loc_wdata};
      end else if (ext_req && ext_we && ext_gnt) begin
        hit = 1'b1;
        got = {1'b0, ext_addr, ext_wdata};
      end
      if (hit) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R11 unexpected write: got to_loc=%0d addr=%h data=%h, expected none",
                   got.to_loc, got.addr, got.data);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (got !== e) begin
            errors++;
            $display("FAIL R11 write mismatch: got to_loc=%0d addr=%h data=%h, expected to_loc=%0d addr=%h data=%h",
                     got.to_loc, got.addr, got.data, e.to_loc, e.addr, e.data);
          end
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] data);
    reg_sel = sel;
    #1;
    data = reg_rdata;
  endtask

  function automatic logic [31:0] shp(input int len_m1, input int rows_m1, input int skip);
    return {skip[11:0], rows_m1[7:0], len_m1[11:0]};
  endfunction

  // driver: predict writes, program, start, and verify the end state
  task automatic run_xfer(input string tag, input bit to_ext, input logic [12:0] loc0,
                          input logic [31:0] ext0, input int len_m1, input int rows_m1,
                          input int skip, input bit exp_ovr);
    logic [12:0] l;
    logic [31:0] e;
    logic [31:0] v;
    int rb;
    bit ovr;
    int wait_n;
    l = loc0;
    e = (ext0[1:0] != 2'b00) ? {ext0[31:3], 3'b000} : ext0;
    rb = ((len_m1 + 1 + 3) / 4) * 4;
    ovr = 1'b0;
    for (int r = 0; r <= rows_m1; r++) begin
      if (int'(l[11:0]) + rb > 4096) ovr = 1'b1;
      for (int w = 0; w < rb / 4; w++) begin
        logic [11:0] off;
        logic [31:0] ea;
        exp_t it;
        off = l[11:0] + 12'(w * 4);
        ea  = e + 32'(w * 4);
        if (!to_ext) begin
          it.to_loc = 1'b1;
          it.addr   = {19'd0, l[12], off[11:2], 2'b00};
          it.data   = ext_mem[ea[11:2]];
        end else begin
          it.to_loc = 1'b0;
          it.addr   = ea;
          it.data   = loc_mem[{l[12], off[11:2]}];
        end
        exp_q.push_back(it);
      end
      l = l + 13'(rb) + (to_ext ? 13'd0 : 13'(skip));
      e = e + 32'(rb) + (to_ext ? 32'(skip) : 32'd0);
    end
    check({tag, " R8 model"}, 32'(ovr), 32'(exp_ovr));
    wr(2'd0, {19'd0, loc0});
    wr(2'd1, ext0);
    wr(to_ext ? 2'd3 : 2'd2, shp(len_m1, rows_m1, skip));
    check({tag, " R9 busy after start"}, 32'(busy), 32'd1);
    rd(2'd1, v);
    check({tag, " R3 aligned ext"}, v, (ext0[1:0] != 2'b00) ? {ext0[31:3], 3'b000} : ext0);
    wait_n = 0;
    while (!done && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    check({tag, " R9 done seen"}, 32'(done), 32'd1);
    check({tag, " R9 busy low at done"}, 32'(busy), 32'd0);
    check({tag, " R8 overrun"}, 32'(overrun), 32'(exp_ovr));
    @(negedge clk);
    check({tag, " R9 done one cycle"}, 32'(done), 32'd0);
    check({tag, " R2 R5 all words moved"}, 32'(exp_q.size()), 32'd0);
    rd(2'd0, v);
    check({tag, " R6 R7 final local"}, v, {19'd0, l});
    rd(2'd1, v);
    check({tag, " R6 R7 final external"}, v, e);
  endtask

  initial begin
    automatic logic [31:0] v;
    reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("reset busy", 32'(busy), 32'd0);
    check("reset done", 32'(done), 32'd0);
    check("reset overrun", 32'(overrun), 32'd0);
    rd(2'd0, v);
    check("reset local addr", v, 32'd0);

    // R2 R4: ext to data bank, 16 bytes, one row
    run_xfer("T1", 1'b0, 13'h0040, 32'h100, 15, 0, 0, 1'b0);
    // R3 R5 R7: unaligned ext, 6 bytes round to 8, 3 rows, skip to local, instr bank
    run_xfer("T2", 1'b0, 13'h1000, 32'h203, 5, 2, 8, 1'b0);
    // R7: local to ext, skip to external, ext aligned to 4 stays
    run_xfer("T3", 1'b1, 13'h0080, 32'h304, 7, 1, 16, 1'b0);
    // R8 R4: row crosses bank end, word index wraps
    run_xfer("T4", 1'b0, 13'h0FF8, 32'h600, 15, 0, 0, 1'b1);
    // R8: row ends exactly at bank end, flag cleared by start
    run_xfer("T5", 1'b0, 13'h0FF0, 32'h620, 15, 0, 0, 1'b0);
    // R2: length field 0x1E gives 31 bytes rounded to 32
    run_xfer("T5b", 1'b1, 13'h1100, 32'h700, 30, 0, 0, 1'b0);

    // R1: zero length start ignored
    wr(2'd0, 32'h0300);
    wr(2'd1, 32'h0500);
    rd(2'd2, v);
    begin
      automatic logic [31:0] shp_before = v;
      automatic int seen_busy = 0;
      wr(2'd2, shp(0, 3, 4));
      for (int i = 0; i < 20; i++) begin
        if (busy || done) seen_busy++;
        @(negedge clk);
      end
      check("R1 no busy or done", 32'(seen_busy), 32'd0);
      rd(2'd2, v);
      check("R1 shape unchanged", v, shp_before);
      rd(2'd0, v);
      check("R1 local unchanged", v, 32'h0300);
      rd(2'd1, v);
      check("R1 ext unchanged", v, 32'h0500);
    end

    // R10: writes during a transfer are ignored
    begin
      automatic int wn = 0;
      for (int w = 0; w < 8; w++) begin
        exp_t it;
        it.to_loc = 1'b1;
        it.addr   = {19'd0, 1'b0, 10'(10'h080 + w), 2'b00};
        it.data   = ext_mem[10'h100 + w];
        exp_q.push_back(it);
      end
      for (int w = 0; w < 8; w++) begin
        exp_t it;
        it.to_loc = 1'b1;
        it.addr   = {19'd0, 1'b0, 10'(10'h088 + w), 2'b00};
        it.data   = ext_mem[10'h108 + w];
        exp_q.push_back(it);
      end
      wr(2'd0, 32'h0200);
      wr(2'd1, 32'h0400);
      wr(2'd2, shp(31, 1, 0));
      wr(2'd3, shp(3, 0, 0));
      wr(2'd0, 32'h0777);
      wr(2'd1, 32'h0999);
      while (!done && wn < 5000) begin
        @(negedge clk);
        wn++;
      end
      check("R10 done seen", 32'(done), 32'd1);
      @(negedge clk);
      check("R10 only first transfer written", 32'(exp_q.size()), 32'd0);
      rd(2'd2, v);
      check("R10 shape kept", v, shp(31, 1, 0));
      rd(2'd0, v);
      check("R10 final local", v, 32'h0240);
      rd(2'd1, v);
      check("R10 final external", v, 32'h0440);
    end

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule